// File: doc/BRIEF.md
# PHY Management Register File

This block is a register-level model of the management register set of an Ethernet PHY, placed behind a small host command front-end. The host first loads an address word that names a PHY address and a register index. It then either loads a 16-bit transmit-data word, which writes the addressed register at once, or pulses a read command. The read copies the addressed register into a receive-data register and samples the link-fail flag at the same time. Serial bit timing, preamble and clock division are not modelled: every access completes in one clock.

The bank holds sixteen 16-bit registers with fixed reset values. The control, status, two identifier, advertisement and link-partner registers have their own behaviour. A link input keeps the link bit of the status register and the abilities in the link-partner register in step with the current link state. A soft-reset bit in the control register restores the whole reset image and keeps the current link state. The status and identifier registers cannot be written.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, register 0 (control) reads 0x1000, register 1 (status) reads 0x7868, register 2 reads 0x2000, register 3 reads 0x5C90, register 4 (advertisement) reads 0x01E1 and register 5 (link partner) reads 0x0000. This assumes the link is down during reset.
- R2: When link_up goes high, bit 2 of register 1 is set and 0x01E1 is ORed into register 5. When link_up goes low, bit 2 of register 1 is cleared and register 5 is ANDed with 0x01FF. The change is visible to a read issued on the next cycle.
- R3: Writes to registers 1, 2 and 3 leave them unchanged.
- R4: A write with a register index of 16 or more changes no register. A read with such an index at PHY address 1 leaves rx_data holding its previous value.
- R5: Only PHY address 1 responds. Writes to any other address change no register, and a read to any other address loads rx_data with 0xFFFF.
- R6: A write to register 0 with bit 15 set reloads every register with its reset value, except that bit 2 of register 1 and the abilities in register 5 follow the current link state. Any other write to register 0 stores the value exactly as given.
- R7: A read command loads rx_data with the addressed register and loads link_fail with the inverse of link_up. Both appear one clock after the command.
- R8: The address word carries the PHY address in bits [4:0] and the register index in bits [12:8]. All other bits are ignored.
- R9: A txd_load pulse stores txd_word and writes it to the addressed register in the same clock. A cmd_write pulse writes the stored transmit word to the currently addressed register.
- R10: Registers 4 to 15, apart from the link updates that R2 makes to register 5, store and return any written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe that loads addr_word |
| addr_word | input | 16 | PHY address [4:0], register index [12:8] |
| txd_load | input | 1 | Strobe that loads txd_word and writes it to the addressed register |
| txd_word | input | 16 | Transmit data word |
| cmd_write | input | 1 | Strobe that writes the stored transmit word to the addressed register |
| cmd_read | input | 1 | Strobe that reads the addressed register into rx_data |
| link_up | input | 1 | Current link state, 1 = up |
| rx_data | output | 16 | Result of the last read |
| link_fail | output | 1 | Inverse of link_up, sampled on the last read |

## Verification
A stale or corrupted register shows up on the very next read: one read command followed by one clock puts the whole 16-bit value on rx_data. A link update that is missed, or applied to the wrong register, shows up as a wrong bit 2 in register 1 or wrong low bits in register 5 on the first read after link_up toggles. A soft reset that loses the link state shows up the same way. Address decode faults also show up one read later. These include a truncated index that aliases index 16 onto register 0, a wrong PHY-address compare, and a write protection that is missing. Each such fault appears as an unexpected value on rx_data, or as a 0xFFFF where register data was expected.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 5;   // width of the PHY-address and index fields
    localparam int IDX_LSB = 8;   // index field position in the address word

    typedef logic [WORD_W-1:0] word_t;

    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_ID_HI = 2;
    localparam int IDX_ID_LO = 3;
    localparam int IDX_ADV   = 4;
    localparam int IDX_LP    = 5;

    localparam word_t CTRL_SOFT_RST = 16'h8000;
    localparam word_t CTRL_INIT     = 16'h1000;
    localparam word_t STAT_INIT     = 16'h7868;
    localparam word_t STAT_LINK     = 16'h0004;
    localparam word_t ID_HI_VAL     = 16'h2000;
    localparam word_t ID_LO_VAL     = 16'h5C90;
    localparam word_t ABILITIES     = 16'h01E1;
    localparam word_t LP_DOWN_KEEP  = 16'h01FF;

    // reset image of one register, before the link state is applied
    function automatic word_t image_word(int idx);
        case (idx)
            IDX_CTRL:  return CTRL_INIT;
            IDX_STAT:  return STAT_INIT;
            IDX_ID_HI: return ID_HI_VAL;
            IDX_ID_LO: return ID_LO_VAL;
            IDX_ADV:   return ABILITIES;
            default:   return '0;
        endcase
    endfunction

    // effect of a link state on one register value
    function automatic word_t link_word(int idx, word_t v, logic up);
        if (idx == IDX_STAT) begin
            return up ? (v | STAT_LINK) : (v & ~STAT_LINK);
        end else if (idx == IDX_LP) begin
            return up ? (v | ABILITIES) : (v & LP_DOWN_KEEP);
        end
        return v;
    endfunction

    function automatic logic is_locked(int idx);
        return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

endpackage

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import phy_mgmt_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic             link_up,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data,
    output logic             rd_hit
);

    localparam int SEL_W = $clog2(NREG);

    typedef struct packed {
        word_t [NREG-1:0] regs;
        logic             link;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  soft_rst;

    always_comb begin
        bank_d   = bank_q;
        soft_rst = 1'b0;
        bank_d.link = link_up;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (32'(wr_idx) == i) && !is_locked(i)) begin
                if ((i == IDX_CTRL) && ((wr_data & CTRL_SOFT_RST) != '0)) begin
                    soft_rst = 1'b1;
                end else begin
                    bank_d.regs[i] = wr_data;
                end
            end
        end
        for (int i = 0; i < NREG; i++) begin
            if (soft_rst) begin
                bank_d.regs[i] = link_word(i, image_word(i), link_up);
            end else if (link_up != bank_q.link) begin
                bank_d.regs[i] = link_word(i, bank_d.regs[i], link_up);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                bank_q.regs[i] <= link_word(i, image_word(i), 1'b0);
            end
            bank_q.link <= 1'b0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_hit  = 32'(rd_idx) < NREG;
    assign rd_data = rd_hit ? bank_q.regs[rd_idx[SEL_W-1:0]] : '0;

    // R2: the link bit always mirrors the link state the bank has taken in
    p_link_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_q.regs[IDX_STAT] & STAT_LINK) != '0) == bank_q.link);

    // R4: an index outside the bank touches nothing
    p_ignore_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) >= NREG) && (link_up == bank_q.link))
        |=> $stable(bank_q.regs));

    // R6: a plain control write is stored as given
    p_ctrl_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) == IDX_CTRL) && !wr_data[WORD_W-1]
         && (link_up == bank_q.link))
        |=> bank_q.regs[IDX_CTRL] == $past(wr_data));

    // R3: write-protected registers stay put
    for (genvar g = 1; g <= 3; g++) begin : g_locked
        p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (32'(wr_idx) == g) && (link_up == bank_q.link))
            |=> $stable(bank_q.regs[g]));
    end

endmodule

// File: rtl/mgmt_front.sv
module mgmt_front
    import phy_mgmt_pkg::*;
#(
    parameter int IDX_W  = FIELD_W,
    parameter int PHY_W  = FIELD_W,
    parameter int PHY_ID = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_load,
    input  word_t            addr_word,
    input  logic             txd_load,
    input  word_t            txd_word,
    input  logic             cmd_write,
    input  logic             cmd_read,
    input  logic             link_up,
    input  word_t            rd_data,
    input  logic             rd_hit,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output word_t            wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output word_t            rx_data,
    output logic             link_fail
);

    typedef struct packed {
        logic [PHY_W-1:0] phy;
        logic [IDX_W-1:0] idx;
        word_t            txd;
        word_t            rx;
        logic             fail;
    } front_t;

    front_t front_d, front_q;
    logic   phy_match;
    logic   unused_addr_bits;

    assign unused_addr_bits = ^{addr_word[WORD_W-1:IDX_LSB+IDX_W],
                                addr_word[IDX_LSB-1:PHY_W]};

    assign phy_match = 32'(front_q.phy) == PHY_ID;
    assign wr_en     = (txd_load || cmd_write) && phy_match;
    assign wr_idx    = front_q.idx;
    assign wr_data   = txd_load ? txd_word : front_q.txd;
    assign rd_idx    = front_q.idx;

    always_comb begin
        front_d = front_q;
        if (addr_load) begin
            front_d.phy = addr_word[PHY_W-1:0];
            front_d.idx = addr_word[IDX_LSB +: IDX_W];
        end
        if (txd_load) begin
            front_d.txd = txd_word;
        end
        if (cmd_read) begin
            front_d.fail = ~link_up;
            if (!phy_match) begin
                front_d.rx = '1;
            end else if (rd_hit) begin
                front_d.rx = rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_q <= '0;
        end else begin
            front_q <= front_d;
        end
    end

    assign rx_data   = front_q.rx;
    assign link_fail = front_q.fail;

    // R5: foreign address reads all ones
    p_foreign_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && !phy_match) |=> rx_data == 16'hFFFF);

    // R7: link-fail is sampled on the read
    p_link_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_read |=> link_fail == !$past(link_up));

    // R7: read data lands one clock later
    p_read_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && phy_match && rd_hit) |=> rx_data == $past(rd_data));

    // R4: out-of-range read keeps the old result
    p_bad_idx_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && phy_match && !rd_hit) |=> $stable(rx_data));

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int PHY_ID = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_load,
    input  logic [15:0] addr_word,
    input  logic        txd_load,
    input  logic [15:0] txd_word,
    input  logic        cmd_write,
    input  logic        cmd_read,
    input  logic        link_up,
    output logic [15:0] rx_data,
    output logic        link_fail
);

    logic               wr_en;
    logic [FIELD_W-1:0] wr_idx;
    word_t              wr_data;
    logic [FIELD_W-1:0] rd_idx;
    word_t              rd_data;
    logic               rd_hit;

    mgmt_front #(
        .IDX_W  (FIELD_W),
        .PHY_W  (FIELD_W),
        .PHY_ID (PHY_ID)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .addr_word (addr_word),
        .txd_load  (txd_load),
        .txd_word  (txd_word),
        .cmd_write (cmd_write),
        .cmd_read  (cmd_read),
        .link_up   (link_up),
        .rd_data   (rd_data),
        .rd_hit    (rd_hit),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rx_data   (rx_data),
        .link_fail (link_fail)
    );

    phy_reg_bank #(
        .NREG  (NREG),
        .IDX_W (FIELD_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .link_up (link_up),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_hit  (rd_hit)
    );

endmodule

// File: tb/test_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module test_phy_mgmt_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [15:0] addr_word = '0;
    logic        txd_load = 1'b0;
    logic [15:0] txd_word = '0;
    logic        cmd_write = 1'b0;
    logic        cmd_read = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] rx_data;
    logic        link_fail;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_regfile i_phy_mgmt_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .addr_word (addr_word),
        .txd_load  (txd_load),
        .txd_word  (txd_word),
        .cmd_write (cmd_write),
        .cmd_read  (cmd_read),
        .link_up   (link_up),
        .rx_data   (rx_data),
        .link_fail (link_fail)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic set_addr_raw(input logic [15:0] w);
        @(negedge clk);
        addr_word = w;
        addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
    endtask

    task automatic set_addr(input logic [4:0] phy, input logic [4:0] idx);
        set_addr_raw({3'b000, idx, 3'b000, phy});
    endtask

    task automatic do_read(output logic [15:0] v, output logic f);
        @(negedge clk);
        cmd_read = 1'b1;
        @(negedge clk);
        cmd_read = 1'b0;
        v = rx_data;
        f = link_fail;
    endtask

    task automatic read_reg(input logic [4:0] phy, input logic [4:0] idx, output logic [15:0] v);
        logic f;
        set_addr(phy, idx);
        do_read(v, f);
    endtask

    task automatic load_txd(input logic [15:0] v);
        @(negedge clk);
        txd_word = v;
        txd_load = 1'b1;
        @(negedge clk);
        txd_load = 1'b0;
    endtask

    task automatic write_reg(input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] v);
        set_addr(phy, idx);
        load_txd(v);
    endtask

    task automatic pulse_write();
        @(negedge clk);
        cmd_write = 1'b1;
        @(negedge clk);
        cmd_write = 1'b0;
    endtask

    task automatic set_link(input logic up);
        @(negedge clk);
        link_up = up;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R7 rx_data after reset", rx_data, 16'h0000);
        read_reg(5'd1, 5'd0, v); check("R1 control", v, 16'h1000);
        read_reg(5'd1, 5'd1, v); check("R1 status", v, 16'h7868);
        read_reg(5'd1, 5'd2, v); check("R1 id hi", v, 16'h2000);
        read_reg(5'd1, 5'd3, v); check("R1 id lo", v, 16'h5C90);
        read_reg(5'd1, 5'd4, v); check("R1 advert", v, 16'h01E1);
        read_reg(5'd1, 5'd5, v); check("R1 partner", v, 16'h0000);
    endtask

    task automatic t_address_fields();
        logic [15:0] v;
        logic f;
        set_addr_raw(16'hE4E1);   // phy 1, index 4, junk elsewhere
        do_read(v, f);
        check("R8 junk address bits", v, 16'h01E1);
    endtask

    task automatic t_link();
        logic [15:0] v;
        logic f;
        set_addr(5'd1, 5'd1);
        do_read(v, f);
        check("R7 link_fail while down", {15'd0, f}, 16'h0001);
        set_link(1'b1);
        set_addr(5'd1, 5'd1);
        do_read(v, f);
        check("R2 status link up", v, 16'h786C);
        check("R7 link_fail while up", {15'd0, f}, 16'h0000);
        read_reg(5'd1, 5'd5, v); check("R2 partner link up", v, 16'h01E1);
        write_reg(5'd1, 5'd5, 16'hFFFF);
        read_reg(5'd1, 5'd5, v); check("R10 partner written", v, 16'hFFFF);
        set_link(1'b0);
        read_reg(5'd1, 5'd1, v); check("R2 status link down", v, 16'h7868);
        read_reg(5'd1, 5'd5, v); check("R2 partner masked", v, 16'h01FF);
    endtask

    task automatic t_locked();
        logic [15:0] v;
        write_reg(5'd1, 5'd1, 16'h0000);
        read_reg(5'd1, 5'd1, v); check("R3 status locked", v, 16'h7868);
        write_reg(5'd1, 5'd2, 16'hABCD);
        read_reg(5'd1, 5'd2, v); check("R3 id hi locked", v, 16'h2000);
        write_reg(5'd1, 5'd3, 16'h1234);
        read_reg(5'd1, 5'd3, v); check("R3 id lo locked", v, 16'h5C90);
    endtask

    task automatic t_generic();
        logic [15:0] v;
        write_reg(5'd1, 5'd15, 16'hA55A);
        read_reg(5'd1, 5'd15, v); check("R10 reg 15", v, 16'hA55A);
        write_reg(5'd1, 5'd4, 16'h0C31);
        read_reg(5'd1, 5'd4, v); check("R10 reg 4", v, 16'h0C31);
        write_reg(5'd1, 5'd0, 16'h0100);
        read_reg(5'd1, 5'd0, v); check("R6 plain control", v, 16'h0100);
    endtask

    task automatic t_bad_index();
        logic [15:0] v;
        logic f;
        write_reg(5'd1, 5'd16, 16'hBEEF);
        write_reg(5'd1, 5'd20, 16'hBEEF);
        read_reg(5'd1, 5'd0, v); check("R4 reg 0 untouched", v, 16'h0100);
        read_reg(5'd1, 5'd4, v); check("R4 reg 4 untouched", v, 16'h0C31);
        set_addr(5'd1, 5'd16);
        do_read(v, f);
        check("R4 read out of range holds", v, 16'h0C31);
    endtask

    task automatic t_foreign();
        logic [15:0] v;
        write_reg(5'd2, 5'd8, 16'h2222);
        read_reg(5'd2, 5'd8, v); check("R5 foreign read", v, 16'hFFFF);
        read_reg(5'd1, 5'd8, v); check("R5 foreign write dropped", v, 16'h0000);
    endtask

    task automatic t_cmd_write();
        logic [15:0] v;
        write_reg(5'd1, 5'd6, 16'h1111);
        read_reg(5'd1, 5'd6, v); check("R9 txd load writes", v, 16'h1111);
        set_addr(5'd1, 5'd7);
        pulse_write();
        read_reg(5'd1, 5'd7, v); check("R9 write command", v, 16'h1111);
    endtask

    task automatic t_soft_reset();
        logic [15:0] v;
        set_link(1'b1);
        write_reg(5'd1, 5'd5, 16'h1234);
        write_reg(5'd1, 5'd0, 16'h8000);
        read_reg(5'd1, 5'd0, v);  check("R6 control reloaded", v, 16'h1000);
        read_reg(5'd1, 5'd4, v);  check("R6 advert reloaded", v, 16'h01E1);
        read_reg(5'd1, 5'd1, v);  check("R6 status keeps link", v, 16'h786C);
        read_reg(5'd1, 5'd5, v);  check("R6 partner reloaded up", v, 16'h01E1);
        read_reg(5'd1, 5'd15, v); check("R6 reg 15 cleared", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address_fields();
        t_link();
        t_locked();
        t_generic();
        t_bad_index();
        t_foreign();
        t_cmd_write();
        t_soft_reset();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule